// File: doc/BRIEF.md
# Seeded-Wiring Boolean Gate Network Classifier

This block runs inference for a trained network of two-input boolean gates that has already been discretized. A binary feature vector goes through a chain of gate layers. Each node in a layer applies one of the sixteen two-variable boolean functions to two outputs of the layer before it. The node's function comes from a 4-bit truth-table code on the `gate_codes` port.

The node-to-node connections are not stored anywhere. At elaboration time they are regenerated from a seed parameter by a 16-bit linear feedback shift register. Any model that uses the same seed therefore reproduces the same wiring.

The outputs of the last layer are split into equal groups, one group per class. The ones in each group are counted to give that class's score. The block reports all the scores and the index of the class with the highest score. Each gate layer is one register stage, and the scoring step adds one more, so a new vector can be accepted on every cycle.

Top module: `lgn_classifier`

## Requirements
- R1: A node with code `k` and wired inputs `a` (first draw) and `b` (second draw) outputs bit `k[{a,b}]`. For example, 4'b1000 is AND, 4'b1110 is OR, 4'b0110 is XOR and 4'b1100 passes `a`.
- R2: Wiring comes from a 16-bit register `s`, initialized to the low 16 bits of `SEED` (or to 1 if those bits are zero).
  - Each step sets `s` to `{s[14:0], s[15]^s[13]^s[12]^s[10]}`.
  - Draw number `j` uses the value of `s` after `j+1` steps, reduced modulo the width of the source layer.
  - Draws are numbered in this order: layer, then node, then input `a` before input `b`, so draw `j = 2*(layer*WIDTH+node)+input`.
  - Layer 0 draws from `in_bits`; every later layer draws from the layer before it.
- R3: All sixteen code values work on every node, including the two constants and the functions that ignore one input.
- R4: Class `c` scores the number of ones among last-layer nodes `c*G` through `c*G+G-1`, where `G = WIDTH/N_CLASSES`. The score sits in `out_scores[c*CNT_W +: CNT_W]`.
- R5: `out_class` is the index of the highest score. When scores tie, the lowest index wins.
- R6: A vector presented with `in_valid` in cycle `k` produces `out_valid` and its results in cycle `k+N_LAYERS+1`. Vectors may be presented on consecutive cycles, and their results come out on consecutive cycles in the same order.
- R7: While `in_valid` is low, `in_bits` is ignored: no `out_valid` is produced, and the output fields keep their values.
- R8: A synchronous reset (`rst` high at a clock edge) drops every vector still in flight and sets `out_valid`, `out_class` and `out_scores` to zero.
- R9: The code for node `n` of layer `l` is `gate_codes[4*(l*WIDTH+n) +: 4]`. The codes must stay stable while the vectors that use them are in flight.
- R10: While `out_valid` is high, `out_class` is below `N_CLASSES` and every score is at most `G`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_bits` as a vector to classify |
| in_bits | input | N_IN | Binary feature vector |
| gate_codes | input | 4*WIDTH*N_LAYERS | Truth-table code of every node |
| out_valid | output | 1 | Result strobe |
| out_class | output | CLS_W | Winning class index |
| out_scores | output | N_CLASSES*CNT_W | Per-class popcounts |

## Verification
The bench builds the block with 8 input bits, three layers of twelve nodes, three classes of four nodes each, and seed 0xACE1. With only 8 input bits, all 256 input vectors can be swept under each of the sixteen uniform gate programs and under three random mixed programs. That sweep includes the constant programs, where every class ties, and the programs whose nodes ignore one input. A reference model, built from the requirements with the same seed rule, predicts every score and class. The bench also measures the exact latency of each result, checks that nothing comes out while `in_valid` is held low, and checks that a reset drops vectors that are still in flight.

// File: rtl/lgn_pkg.sv
package lgn_pkg;

  localparam int unsigned CODE_BITS = 4;

  // one step of the wiring sequence generator
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // source index for a given draw number, reduced to the source layer width
  function automatic int unsigned wire_src(input int unsigned seed,
                                           input int unsigned draw,
                                           input int unsigned span);
    logic [15:0] s;
    s = seed[15:0];
    if (s == 16'h0) s = 16'h1;
    for (int unsigned k = 0; k <= draw; k++) s = lfsr_step(s);
    return 32'(s) % span;
  endfunction

  // truth-table lookup: the bit at index {a,b}
  function automatic logic gate_eval(input logic [CODE_BITS-1:0] code,
                                     input logic a, input logic b);
    return code[{a, b}];
  endfunction

endpackage

// File: rtl/lgn_layer.sv
module lgn_layer #(
  parameter int unsigned LAYER = 0,
  parameter int unsigned IN_W  = 8,
  parameter int unsigned WIDTH = 12,
  parameter int unsigned SEED  = 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               vi,
  input  logic [IN_W-1:0]                    di,
  input  logic [lgn_pkg::CODE_BITS*WIDTH-1:0] codes,
  output logic                               vo,
  output logic [WIDTH-1:0]                   dq
);
  localparam int unsigned CB = lgn_pkg::CODE_BITS;

  logic [WIDTH-1:0] node_val;

  for (genvar n = 0; n < WIDTH; n++) begin : g_node
    localparam int unsigned DRAW  = 2 * (LAYER * WIDTH + n);
    localparam int unsigned SRC_A = lgn_pkg::wire_src(SEED, DRAW, IN_W);
    localparam int unsigned SRC_B = lgn_pkg::wire_src(SEED, DRAW + 1, IN_W);
    assign node_val[n] = lgn_pkg::gate_eval(codes[CB*n +: CB], di[SRC_A], di[SRC_B]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vo <= 1'b0;
      dq <= '0;
    end else begin
      vo <= vi;
      if (vi) dq <= node_val;
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !vi |=> $stable(dq));

endmodule

// File: rtl/lgn_score.sv
module lgn_score #(
  parameter int unsigned WIDTH     = 12,
  parameter int unsigned N_CLASSES = 3,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned CLS_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         vi,
  input  logic [WIDTH-1:0]             di,
  output logic                         vo,
  output logic [CLS_W-1:0]             cls,
  output logic [N_CLASSES*CNT_W-1:0]   scores
);
  localparam int unsigned GRP = WIDTH / N_CLASSES;

  logic [N_CLASSES*CNT_W-1:0] cnt_flat;
  logic [CLS_W-1:0]           best_c;
  logic [CNT_W-1:0]           best_s;

  for (genvar c = 0; c < N_CLASSES; c++) begin : g_grp
    logic [CNT_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < GRP; i++) acc = acc + CNT_W'(di[c*GRP + i]);
    end
    assign cnt_flat[c*CNT_W +: CNT_W] = acc;
  end

  // strict comparison keeps the earliest class on a tie
  always_comb begin
    best_c = '0;
    best_s = cnt_flat[0 +: CNT_W];
    for (int c = 1; c < N_CLASSES; c++) begin
      if (cnt_flat[c*CNT_W +: CNT_W] > best_s) begin
        best_s = cnt_flat[c*CNT_W +: CNT_W];
        best_c = CLS_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vo     <= 1'b0;
      cls    <= '0;
      scores <= '0;
    end else begin
      vo <= vi;
      if (vi) begin
        cls    <= best_c;
        scores <= cnt_flat;
      end
    end
  end

  // checker: re-derive argmax and bounds from the registered outputs
  logic             arg_ok;
  logic             bound_ok;
  logic [CNT_W-1:0] win_s;
  logic [CNT_W-1:0] cur_s;

  always_comb begin
    win_s    = '0;
    arg_ok   = (32'(cls) < N_CLASSES);
    bound_ok = 1'b1;
    cur_s    = '0;
    for (int c = 0; c < N_CLASSES; c++)
      if (CLS_W'(c) == cls) win_s = scores[c*CNT_W +: CNT_W];
    for (int c = 0; c < N_CLASSES; c++) begin
      cur_s = scores[c*CNT_W +: CNT_W];
      if (cur_s > win_s) arg_ok = 1'b0;
      if ((CLS_W'(c) < cls) && (cur_s >= win_s)) arg_ok = 1'b0;
      if (32'(cur_s) > GRP) bound_ok = 1'b0;
    end
  end

  // R5
  argmax_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    vo |-> arg_ok);

  // R10
  score_bound_chk: assert property (@(posedge clk) disable iff (rst)
    vo |-> bound_ok);

endmodule

// File: rtl/lgn_classifier.sv
module lgn_classifier #(
  parameter  int unsigned N_IN      = 16,
  parameter  int unsigned WIDTH     = 24,
  parameter  int unsigned N_LAYERS  = 4,
  parameter  int unsigned N_CLASSES = 4,
  parameter  int unsigned SEED      = 32'hACE1,
  localparam int unsigned GRP       = WIDTH / N_CLASSES,
  localparam int unsigned CNT_W     = $clog2(GRP + 1),
  localparam int unsigned CLS_W     = (N_CLASSES > 1) ? $clog2(N_CLASSES) : 1,
  localparam int unsigned LAYER_CW  = lgn_pkg::CODE_BITS * WIDTH,
  localparam int unsigned CODE_W    = LAYER_CW * N_LAYERS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [N_IN-1:0]            in_bits,
  input  logic [CODE_W-1:0]          gate_codes,
  output logic                       out_valid,
  output logic [CLS_W-1:0]           out_class,
  output logic [N_CLASSES*CNT_W-1:0] out_scores
);
  localparam int unsigned QW = $clog2(N_LAYERS + 3);

  if ((WIDTH % N_CLASSES) != 0 || N_LAYERS < 1 || N_LAYERS > 6) begin : g_bad_cfg
    $error("lgn_classifier: WIDTH must split evenly into classes and depth must be 1..6");
  end

  logic [N_LAYERS-1:0] lay_v;
  logic [WIDTH-1:0]    lay_d [N_LAYERS];

  for (genvar l = 0; l < N_LAYERS; l++) begin : g_layer
    if (l == 0) begin : g_first
      lgn_layer #(.LAYER(0), .IN_W(N_IN), .WIDTH(WIDTH), .SEED(SEED)) u_layer (
        .clk   (clk),
        .rst   (rst),
        .vi    (in_valid),
        .di    (in_bits),
        .codes (gate_codes[0 +: LAYER_CW]),
        .vo    (lay_v[0]),
        .dq    (lay_d[0])
      );
    end else begin : g_next
      lgn_layer #(.LAYER(l), .IN_W(WIDTH), .WIDTH(WIDTH), .SEED(SEED)) u_layer (
        .clk   (clk),
        .rst   (rst),
        .vi    (lay_v[l-1]),
        .di    (lay_d[l-1]),
        .codes (gate_codes[l*LAYER_CW +: LAYER_CW]),
        .vo    (lay_v[l]),
        .dq    (lay_d[l])
      );
    end
  end

  lgn_score #(.WIDTH(WIDTH), .N_CLASSES(N_CLASSES), .CNT_W(CNT_W), .CLS_W(CLS_W)) u_score (
    .clk    (clk),
    .rst    (rst),
    .vi     (lay_v[N_LAYERS-1]),
    .di     (lay_d[N_LAYERS-1]),
    .vo     (out_valid),
    .cls    (out_class),
    .scores (out_scores)
  );

  // checker: cycles since the last accepted vector, saturating
  logic [QW-1:0] quiet;
  always_ff @(posedge clk) begin
    if (rst)                           quiet <= '0;
    else if (in_valid)                 quiet <= '0;
    else if (32'(quiet) <= N_LAYERS)   quiet <= quiet + 1'b1;
  end

  // R6
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(quiet) > N_LAYERS) |-> !out_valid);

endmodule

// File: tb/lgn_classifier_tb_top.sv
module lgn_classifier_tb_top;
  localparam int unsigned N_IN      = 8;
  localparam int unsigned WIDTH     = 12;
  localparam int unsigned N_LAYERS  = 3;
  localparam int unsigned N_CLASSES = 3;
  localparam int unsigned SEED      = 32'hACE1;
  localparam int unsigned GRP       = WIDTH / N_CLASSES;
  localparam int unsigned CNT_W     = $clog2(GRP + 1);
  localparam int unsigned CLS_W     = (N_CLASSES > 1) ? $clog2(N_CLASSES) : 1;
  localparam int unsigned CODE_W    = 4 * WIDTH * N_LAYERS;
  localparam int          MAXV      = 8192;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic                       in_valid = 1'b0;
  logic [N_IN-1:0]            in_bits = '0;
  logic [CODE_W-1:0]          gate_codes = '0;
  logic                       out_valid;
  logic [CLS_W-1:0]           out_class;
  logic [N_CLASSES*CNT_W-1:0] out_scores;

  int compared = 0, mismatched = 0, cyc = 0;
  int issued = 0, got = 0;
  int src_a [N_LAYERS][WIDTH];
  int src_b [N_LAYERS][WIDTH];
  int exp_cls [MAXV];
  int exp_sc  [MAXV][N_CLASSES];
  int iss_cyc [MAXV];
  int m_cls;
  int m_sc [N_CLASSES];

  lgn_classifier #(.N_IN(N_IN), .WIDTH(WIDTH), .N_LAYERS(N_LAYERS),
                   .N_CLASSES(N_CLASSES), .SEED(SEED)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
    .gate_codes(gate_codes), .out_valid(out_valid), .out_class(out_class),
    .out_scores(out_scores)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // wiring rule of R2
  function automatic int draw_src(input int draw, input int span);
    logic [15:0] s;
    s = SEED[15:0];
    if (s == 16'h0) s = 16'h1;
    for (int k = 0; k <= draw; k++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    return int'(s) % span;
  endfunction

  // reference from R1, R4, R5, R9
  task automatic model(input logic [N_IN-1:0] v);
    logic [WIDTH-1:0] cur, nxt;
    logic a, b;
    logic [3:0] code;
    cur = '0;
    nxt = '0;
    for (int l = 0; l < N_LAYERS; l++) begin
      for (int n = 0; n < WIDTH; n++) begin
        if (l == 0) begin a = v[src_a[l][n]];   b = v[src_b[l][n]];   end
        else        begin a = cur[src_a[l][n]]; b = cur[src_b[l][n]]; end
        code = gate_codes[(l*WIDTH + n)*4 +: 4];
        nxt[n] = code[{a, b}];
      end
      cur = nxt;
    end
    for (int c = 0; c < N_CLASSES; c++) begin
      m_sc[c] = 0;
      for (int i = 0; i < GRP; i++) m_sc[c] += int'(cur[c*GRP + i]);
    end
    m_cls = 0;
    for (int c = 1; c < N_CLASSES; c++) if (m_sc[c] > m_sc[m_cls]) m_cls = c;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (got >= issued) begin
        chk(1'b0, "R7 out_valid with nothing in flight", 1, 0);
      end else begin
        chk(cyc - iss_cyc[got] == N_LAYERS + 1, "R6 latency", cyc - iss_cyc[got], N_LAYERS + 1);
        for (int c = 0; c < N_CLASSES; c++)
          chk(int'(out_scores[c*CNT_W +: CNT_W]) == exp_sc[got][c],
              "R4 score (gates R1 R3, wiring R2, codes R9)",
              int'(out_scores[c*CNT_W +: CNT_W]), exp_sc[got][c]);
        chk(int'(out_class) == exp_cls[got], "R5 class", int'(out_class), exp_cls[got]);
        got++;
      end
    end
  end

  task automatic sweep();
    for (int v = 0; v < (1 << N_IN); v++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bits  = N_IN'(v);
      model(N_IN'(v));
      exp_cls[issued] = m_cls;
      for (int c = 0; c < N_CLASSES; c++) exp_sc[issued][c] = m_sc[c];
      iss_cyc[issued] = cyc;
      issued++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (N_LAYERS + 3) @(negedge clk);
    chk(got == issued, "R6 every result delivered in order", got, issued);
  endtask

  initial begin
    int idle_hits;
    logic [CLS_W-1:0] held_cls;
    logic [N_CLASSES*CNT_W-1:0] held_sc;

    for (int l = 0; l < N_LAYERS; l++)
      for (int n = 0; n < WIDTH; n++) begin
        src_a[l][n] = draw_src(2*(l*WIDTH + n),     (l == 0) ? N_IN : WIDTH);
        src_b[l][n] = draw_src(2*(l*WIDTH + n) + 1, (l == 0) ? N_IN : WIDTH);
      end

    repeat (3) @(negedge clk);
    // R8 reset state
    chk(out_valid == 1'b0, "R8 out_valid at reset", int'(out_valid), 0);
    chk(out_class == '0, "R8 out_class at reset", int'(out_class), 0);
    chk(out_scores == '0, "R8 out_scores at reset", int'(out_scores), 0);
    rst = 1'b0;

    // R3: every code on every node, all input vectors
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < N_LAYERS*WIDTH; i++) gate_codes[i*4 +: 4] = 4'(k);
      sweep();
    end
    // mixed programs
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N_LAYERS*WIDTH; i++) gate_codes[i*4 +: 4] = 4'($urandom);
      sweep();
    end

    // R7: toggling data without the strobe
    held_cls  = out_class;
    held_sc   = out_scores;
    idle_hits = 0;
    for (int t = 0; t < 24; t++) begin
      @(negedge clk);
      in_bits = N_IN'($urandom);
      if (out_valid) idle_hits++;
    end
    chk(idle_hits == 0, "R7 no strobe while idle", idle_hits, 0);
    chk(out_class == held_cls, "R7 class held while idle", int'(out_class), int'(held_cls));
    chk(out_scores == held_sc, "R7 scores held while idle", int'(out_scores), int'(held_sc));

    // R8: reset drops vectors in flight
    for (int i = 0; i < N_LAYERS*WIDTH; i++) gate_codes[i*4 +: 4] = 4'b1111;
    @(negedge clk); in_valid = 1'b1; in_bits = 8'h3C;
    @(negedge clk); in_bits = 8'hA5;
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid cleared", int'(out_valid), 0);
    chk(out_class == '0, "R8 out_class cleared", int'(out_class), 0);
    chk(out_scores == '0, "R8 out_scores cleared", int'(out_scores), 0);
    rst = 1'b0;
    idle_hits = 0;
    for (int t = 0; t < N_LAYERS + 4; t++) begin
      @(negedge clk);
      if (out_valid) idle_hits++;
    end
    chk(idle_hits == 0, "R8 in-flight vectors dropped", idle_hits, 0);
    got = issued;

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", got, issued);
    summary();
    $finish;
  end

endmodule